// File: doc/BRIEF.md
# Analog Memory Readout and Conversion Sequencer

This block is the control state machine that runs one read-and-digitise cycle of a multi-channel analog memory that feeds a ramp-type ADC bank. Each cycle, on a start request, it places a cell address on the read address bus and then releases the read amplifier from reset. It then enables the read path and waits a programmable settling time. Next it pulses the comparator auto-zero, and after that the comparator input switch, which moves the comparators from the memory output onto the ramp. Finally it opens the conversion clock gate. The conversion ends when the full-scale flag comes back or when a programmable timeout expires. The sequencer then closes the gate, strobes the result registers with a one-cycle load pulse and scans the channel addresses out, one channel per cycle, with a data-valid qualifier.

In difference mode the block reads two cells. The first cell is read and settles with the connect switch closed. The switch then opens while the amplifier is reset and settles. The second cell is read and settles. The switch then closes again for a last settling window. A programmable floor on the total setup length applies in this mode. All durations are inputs counted in control-clock cycles. Scan-out runs on its own engine, so the setup of the next cycle proceeds while the previous results stream out. The load pulse for a new result is held back until the running scan has finished.

Top module: `amu_conv_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, amp_rst_o and conn_o are 1 and rd_en_o, az_o, ics_o, conv_en_o, load_o and dv_o are 0. A reset during a running cycle returns the outputs to this idle state.
- R2: A start_i sampled high while idle begins a cycle. In its first cycle rd_addr_o shows cell_a_i with amp_rst_o high. The next cycle has amp_rst_o low and rd_en_o low. rd_en_o rises only after that. rd_en_o and amp_rst_o are never high together.
- R3: After read settling, az_o is high for az_len_i cycles and then ics_o is high for ics_len_i cycles before conversion. The two are never high together. A length of 0 counts as 1.
- R4: conv_en_o is only high with ics_o high. It falls in the cycle after fsc_i is sampled high, or after timeout_len_i cycles, whichever comes first.
- R5: load_o is a single-cycle pulse in the first cycle with conv_en_o low after a conversion, provided no scan is running.
- R6: Starting the cycle after load_o, dv_o is high for exactly 32 consecutive cycles, with chan_o stepping 0, 1, ..., 31.
- R7: A new start is accepted in the cycle after load_o, so setup runs during scan-out. If a conversion ends while a scan runs, load_o waits until the first cycle after the last dv_o. load_o and dv_o are never high together.
- R8: start_i is ignored unless the sequencer is idle.
- R9: With corr_mode_i = 1, conn_o is low for exactly 2*S+2 cycles (S = settle_len_i, 0 counting as 1). That window covers the reset settle, the second address, the release and the second read settle. conn_o then returns high while rd_addr_o shows cell_b_i. No auto-zero, input switch or conversion occurs while conn_o is low.
- R10: With corr_mode_i = 1, the number of cycles from the first setup cycle to the first conv_en_o cycle is max(4+4*S, CORR_MIN_CYC) + az_len_i + ics_len_i.
- R11: With corr_mode_i = 0, conn_o stays high throughout. That same count is 2 + S + az_len_i + ics_len_i, and rd_addr_o stays at cell_a_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a read-and-convert cycle (taken when idle) |
| corr_mode_i | input | 1 | 1 selects two-cell difference mode |
| cell_a_i | input | CELL_W | First (or only) cell address |
| cell_b_i | input | CELL_W | Second cell address for difference mode |
| fsc_i | input | 1 | Full-scale count flag from the ADC |
| settle_len_i | input | DUR_W | Amplifier settling length in cycles |
| az_len_i | input | DUR_W | Auto-zero pulse length in cycles |
| ics_len_i | input | DUR_W | Input-switch lead time in cycles |
| timeout_len_i | input | DUR_W | Conversion timeout in cycles |
| rd_addr_o | output | CELL_W | Read address to the memory |
| amp_rst_o | output | 1 | Read amplifier reset |
| rd_en_o | output | 1 | Read enable |
| conn_o | output | 1 | Difference-stage connect switch |
| az_o | output | 1 | Comparator auto-zero |
| ics_o | output | 1 | Comparator input switch (1 = ramp) |
| conv_en_o | output | 1 | Conversion clock enable |
| load_o | output | 1 | Result register load strobe |
| chan_o | output | CH_W | Scan-out channel address |
| dv_o | output | 1 | Scan-out data valid |

## Verification
A wrong phase state shows up within one cycle as an illegal strobe pair: read enable during amplifier reset, auto-zero with the input switch, a clock gate without the ramp switch, or a load during scan. A wrong duration count shows up as a setup length or conversion width that differs from the closed-form cycle count, and that count is measured at the ports on every vector. A broken scan counter or hold-off is caught on the first channel step that is out of order. It is also caught when a load that arrives during a scan fails to land exactly after the 32nd valid cycle.

// File: rtl/amu_seq_pkg.sv
// Shared types for the readout-conversion sequencer.
// Assumes: one control clock domain, all durations in cycles of it.
package amu_seq_pkg;

    // Phases of one read-and-convert cycle
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_A,
        ST_REL_A,
        ST_SET_A,
        ST_RST_MID,
        ST_ADDR_B,
        ST_REL_B,
        ST_SET_B,
        ST_JOIN,
        ST_AZ,
        ST_ICS,
        ST_CONV,
        ST_DONE
    } seq_state_e;

    // Control strobes driven toward the analog chip
    typedef struct packed {
        logic amp_rst;
        logic rd_en;
        logic conn;
        logic az;
        logic ics;
        logic conv_en;
    } strobe_t;

endpackage

// File: rtl/seq_phase_timer.sv
// Phase duration counter.
// Counts cycles since the last restart and flags the last cycle of a
// phase of len_i cycles. A length of 0 behaves as 1. Saturates at its
// maximum, so the flag stays high once reached.
module seq_phase_timer #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [DUR_W-1:0] len_i,
    output logic             last_o
);
    localparam logic [DUR_W-1:0] INC  = 1;
    localparam logic [DUR_W:0]   INCW = 1;

    logic [DUR_W-1:0] cnt_q;

    // cycle counter, cleared on phase entry
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + INC;
        end
    end

    // last cycle when elapsed+1 reaches the programmed length
    assign last_o = ({1'b0, cnt_q} + INCW) >= {1'b0, len_i};

endmodule

// File: rtl/seq_scan_engine.sv
// Scan-out engine.
// A one-cycle kick starts a sweep of NCH channel addresses, one per
// cycle, with a valid flag. Assumes kick only arrives while idle.
module seq_scan_engine #(
    parameter  int NCH  = 32,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kick_i,
    output logic            active_o,
    output logic [CH_W-1:0] chan_o
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);
    localparam logic [CH_W-1:0] STEP = 1;

    logic            active_q;
    logic [CH_W-1:0] chan_q;

    // sweep channel index from 0 to NCH-1 after a kick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            chan_q   <= '0;
        end else if (kick_i) begin
            active_q <= 1'b1;
            chan_q   <= '0;
        end else if (active_q) begin
            if (chan_q == LAST) begin
                active_q <= 1'b0;
            end else begin
                chan_q <= chan_q + STEP;
            end
        end
    end

    assign active_o = active_q;
    assign chan_o   = chan_q;

endmodule

// File: rtl/seq_front_fsm.sv
// Setup and conversion state machine.
// Walks the address / release / settle / auto-zero / input-switch /
// convert phases, with a two-cell difference variant. Phase lengths
// come from an external timer (phase_len_o out, phase_last_i back).
// Assumes: scan_busy_i reflects the scan engine in the same cycle.
module seq_front_fsm
    import amu_seq_pkg::*;
#(
    parameter int          CELL_W       = 6,
    parameter int          DUR_W        = 16,
    parameter int unsigned CORR_MIN_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              corr_i,
    input  logic [CELL_W-1:0] cell_a_i,
    input  logic [CELL_W-1:0] cell_b_i,
    input  logic              fsc_i,
    input  logic [DUR_W-1:0]  settle_len_i,
    input  logic [DUR_W-1:0]  az_len_i,
    input  logic [DUR_W-1:0]  ics_len_i,
    input  logic [DUR_W-1:0]  timeout_len_i,
    input  logic              scan_busy_i,
    input  logic              phase_last_i,
    output logic              phase_restart_o,
    output logic [DUR_W-1:0]  phase_len_o,
    output logic [CELL_W-1:0] rd_addr_o,
    output strobe_t           strobe_o,
    output logic              load_o
);
    localparam logic [DUR_W-1:0] INC = 1;

    seq_state_e        state_q, state_d;
    logic              corr_q;
    logic              use_b_q;
    logic [CELL_W-1:0] cell_a_q, cell_b_q;
    logic [DUR_W-1:0]  elapsed_q;
    logic              accept;
    logic              in_setup;
    logic              floor_ok;

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign in_setup = state_q inside {ST_ADDR_A, ST_REL_A, ST_SET_A, ST_RST_MID,
                                      ST_ADDR_B, ST_REL_B, ST_SET_B, ST_JOIN};
    assign floor_ok = (32'(elapsed_q) + 32'd1) >= CORR_MIN_CYC;

    // next-phase selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ADDR_A;
            ST_ADDR_A:  state_d = ST_REL_A;
            ST_REL_A:   state_d = ST_SET_A;
            ST_SET_A:   if (phase_last_i) state_d = corr_q ? ST_RST_MID : ST_AZ;
            ST_RST_MID: if (phase_last_i) state_d = ST_ADDR_B;
            ST_ADDR_B:  state_d = ST_REL_B;
            ST_REL_B:   state_d = ST_SET_B;
            ST_SET_B:   if (phase_last_i) state_d = ST_JOIN;
            ST_JOIN:    if (phase_last_i && floor_ok) state_d = ST_AZ;
            ST_AZ:      if (phase_last_i) state_d = ST_ICS;
            ST_ICS:     if (phase_last_i) state_d = ST_CONV;
            ST_CONV:    if (fsc_i || phase_last_i) state_d = ST_DONE;
            ST_DONE:    if (!scan_busy_i) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // capture mode and addresses when a cycle is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_q   <= 1'b0;
            cell_a_q <= '0;
            cell_b_q <= '0;
        end else if (accept) begin
            corr_q   <= corr_i;
            cell_a_q <= cell_a_i;
            cell_b_q <= cell_b_i;
        end
    end

    // steer read address to the second cell once it is addressed
    always_ff @(posedge clk) begin
        if (!rst_n || accept)          use_b_q <= 1'b0;
        else if (state_d == ST_ADDR_B) use_b_q <= 1'b1;
    end

    // setup-length counter for the difference-mode floor
    always_ff @(posedge clk) begin
        if (!rst_n || accept)              elapsed_q <= '0;
        else if (in_setup && elapsed_q != '1) elapsed_q <= elapsed_q + INC;
    end

    // length of the phase currently running
    always_comb begin
        unique case (state_q)
            ST_SET_A, ST_RST_MID, ST_SET_B, ST_JOIN: phase_len_o = settle_len_i;
            ST_AZ:   phase_len_o = az_len_i;
            ST_ICS:  phase_len_o = ics_len_i;
            ST_CONV: phase_len_o = timeout_len_i;
            default: phase_len_o = '0;
        endcase
    end

    // strobe decode per phase
    always_comb begin
        strobe_o.amp_rst = 1'b1;
        strobe_o.rd_en   = 1'b0;
        strobe_o.conn    = 1'b1;
        strobe_o.az      = 1'b0;
        strobe_o.ics     = 1'b0;
        strobe_o.conv_en = 1'b0;
        unique case (state_q)
            ST_REL_A: strobe_o.amp_rst = 1'b0;
            ST_SET_A, ST_JOIN: begin
                strobe_o.amp_rst = 1'b0;
                strobe_o.rd_en   = 1'b1;
            end
            ST_RST_MID, ST_ADDR_B: strobe_o.conn = 1'b0;
            ST_REL_B: begin
                strobe_o.amp_rst = 1'b0;
                strobe_o.conn    = 1'b0;
            end
            ST_SET_B: begin
                strobe_o.amp_rst = 1'b0;
                strobe_o.rd_en   = 1'b1;
                strobe_o.conn    = 1'b0;
            end
            ST_AZ: begin
                strobe_o.amp_rst = 1'b0;
                strobe_o.rd_en   = 1'b1;
                strobe_o.az      = 1'b1;
            end
            ST_ICS: begin
                strobe_o.amp_rst = 1'b0;
                strobe_o.rd_en   = 1'b1;
                strobe_o.ics     = 1'b1;
            end
            ST_CONV: begin
                strobe_o.amp_rst = 1'b0;
                strobe_o.rd_en   = 1'b1;
                strobe_o.ics     = 1'b1;
                strobe_o.conv_en = 1'b1;
            end
            default: ;
        endcase
    end

    assign phase_restart_o = (state_d != state_q);
    assign rd_addr_o       = use_b_q ? cell_b_q : cell_a_q;
    assign load_o          = (state_q == ST_DONE) && !scan_busy_i;

endmodule

// File: rtl/amu_conv_seq.sv
// Top of the readout-conversion sequencer.
// Joins the setup/convert state machine, its phase timer and the
// scan-out engine. The load pulse is the handoff between the two halves.
module amu_conv_seq
    import amu_seq_pkg::*;
#(
    parameter  int          NCH          = 32,
    parameter  int          CELL_W       = 6,
    parameter  int          DUR_W        = 16,
    parameter  int unsigned CORR_MIN_CYC = 1000,
    localparam int          CH_W         = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              corr_mode_i,
    input  logic [CELL_W-1:0] cell_a_i,
    input  logic [CELL_W-1:0] cell_b_i,
    input  logic              fsc_i,
    input  logic [DUR_W-1:0]  settle_len_i,
    input  logic [DUR_W-1:0]  az_len_i,
    input  logic [DUR_W-1:0]  ics_len_i,
    input  logic [DUR_W-1:0]  timeout_len_i,
    output logic [CELL_W-1:0] rd_addr_o,
    output logic              amp_rst_o,
    output logic              rd_en_o,
    output logic              conn_o,
    output logic              az_o,
    output logic              ics_o,
    output logic              conv_en_o,
    output logic              load_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              dv_o
);
    strobe_t          strobe;
    logic             scan_busy;
    logic             phase_restart;
    logic             phase_last;
    logic [DUR_W-1:0] phase_len;

    seq_front_fsm #(
        .CELL_W       (CELL_W),
        .DUR_W        (DUR_W),
        .CORR_MIN_CYC (CORR_MIN_CYC)
    ) u_front (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .corr_i          (corr_mode_i),
        .cell_a_i        (cell_a_i),
        .cell_b_i        (cell_b_i),
        .fsc_i           (fsc_i),
        .settle_len_i    (settle_len_i),
        .az_len_i        (az_len_i),
        .ics_len_i       (ics_len_i),
        .timeout_len_i   (timeout_len_i),
        .scan_busy_i     (scan_busy),
        .phase_last_i    (phase_last),
        .phase_restart_o (phase_restart),
        .phase_len_o     (phase_len),
        .rd_addr_o       (rd_addr_o),
        .strobe_o        (strobe),
        .load_o          (load_o)
    );

    seq_phase_timer #(.DUR_W(DUR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (phase_restart),
        .len_i     (phase_len),
        .last_o    (phase_last)
    );

    seq_scan_engine #(.NCH(NCH)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick_i   (load_o),
        .active_o (scan_busy),
        .chan_o   (chan_o)
    );

    assign amp_rst_o = strobe.amp_rst;
    assign rd_en_o   = strobe.rd_en;
    assign conn_o    = strobe.conn;
    assign az_o      = strobe.az;
    assign ics_o     = strobe.ics;
    assign conv_en_o = strobe.conv_en;
    assign dv_o      = scan_busy;

endmodule

// File: rtl/amu_conv_seq_chk.sv
// Protocol checker for the readout-conversion sequencer, bound to the top.
// Watches only the top-level ports.
module amu_conv_seq_chk #(
    parameter  int NCH  = 32,
    localparam int CH_W = $clog2(NCH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            amp_rst_o,
    input logic            rd_en_o,
    input logic            conn_o,
    input logic            az_o,
    input logic            ics_o,
    input logic            conv_en_o,
    input logic            load_o,
    input logic [CH_W-1:0] chan_o,
    input logic            dv_o
);
    // R1: first cycle after reset release is idle
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (amp_rst_o && conn_o && !rd_en_o && !conv_en_o && !load_o && !dv_o));

    // R2: read enable never overlaps amplifier reset
    a_r2_no_read_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_o && amp_rst_o));

    // R2: read enable rises only from a released amplifier
    a_r2_release_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en_o) |-> !$past(amp_rst_o));

    // R3: auto-zero and input switch are exclusive
    a_r3_az_ics_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(az_o && ics_o));

    // R4: conversion clock only with the ramp connected
    a_r4_conv_needs_ics: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en_o |-> ics_o);

    // R5: load is a single pulse outside conversion
    a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
    a_r5_load_no_conv: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> !conv_en_o);

    // R6: channel steps by one while valid continues
    a_r6_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_o && $past(dv_o)) |-> (chan_o == CH_W'($past(chan_o) + 1'b1)));

    // R7: no load during a running scan
    a_r7_no_load_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_o && dv_o));

    // R9: nothing toward the comparators while the connect switch is open
    a_r9_conn_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !conn_o |-> (!conv_en_o && !az_o && !ics_o));

endmodule

bind amu_conv_seq amu_conv_seq_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .amp_rst_o (amp_rst_o),
    .rd_en_o   (rd_en_o),
    .conn_o    (conn_o),
    .az_o      (az_o),
    .ics_o     (ics_o),
    .conv_en_o (conv_en_o),
    .load_o    (load_o),
    .chan_o    (chan_o),
    .dv_o      (dv_o)
);

// File: tb/sim_amu_conv_seq.sv
// Bench for the readout-conversion sequencer: vector table, then directed tests.
module sim_amu_conv_seq;
    localparam int NCH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        corr_mode_i = 1'b0;
    logic [5:0]  cell_a_i = '0;
    logic [5:0]  cell_b_i = '0;
    logic        fsc_i = 1'b0;
    logic [15:0] settle_len_i = 16'd1;
    logic [15:0] az_len_i = 16'd1;
    logic [15:0] ics_len_i = 16'd1;
    logic [15:0] timeout_len_i = 16'd10;
    logic [5:0]  rd_addr_o;
    logic        amp_rst_o, rd_en_o, conn_o, az_o, ics_o, conv_en_o, load_o, dv_o;
    logic [4:0]  chan_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    amu_conv_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .corr_mode_i(corr_mode_i),
        .cell_a_i(cell_a_i), .cell_b_i(cell_b_i), .fsc_i(fsc_i),
        .settle_len_i(settle_len_i), .az_len_i(az_len_i), .ics_len_i(ics_len_i),
        .timeout_len_i(timeout_len_i), .rd_addr_o(rd_addr_o), .amp_rst_o(amp_rst_o),
        .rd_en_o(rd_en_o), .conn_o(conn_o), .az_o(az_o), .ics_o(ics_o),
        .conv_en_o(conv_en_o), .load_o(load_o), .chan_o(chan_o), .dv_o(dv_o)
    );

    typedef struct packed {
        logic        corr;
        logic [5:0]  a;
        logic [5:0]  b;
        logic [15:0] s, z, i, d, t;
        logic [15:0] exp_pre, exp_conv, exp_az, exp_ics, exp_connlo;
    } vec_t;

    // stimulus: mode, cells, settle, az, ics, fsc delay, timeout | expected
    localparam vec_t VECS [6] = '{
        '{1'b0, 6'd3,  6'd9,  16'd5,   16'd3,  16'd4,  16'd7,   16'd50,  16'd14,   16'd7,  16'd3,  16'd4,  16'd0},
        '{1'b0, 6'd0,  6'd63, 16'd0,   16'd0,  16'd0,  16'd1,   16'd9,   16'd5,    16'd1,  16'd1,  16'd1,  16'd0},
        '{1'b0, 6'd63, 6'd0,  16'd20,  16'd10, 16'd10, 16'd500, 16'd30,  16'd42,   16'd30, 16'd10, 16'd10, 16'd0},
        '{1'b1, 6'd17, 6'd42, 16'd10,  16'd2,  16'd3,  16'd4,   16'd100, 16'd1005, 16'd4,  16'd2,  16'd3,  16'd22},
        '{1'b1, 6'd5,  6'd6,  16'd300, 16'd10, 16'd10, 16'd12,  16'd12,  16'd1224, 16'd12, 16'd10, 16'd10, 16'd602},
        '{1'b0, 6'd31, 6'd32, 16'd250, 16'd10, 16'd10, 16'd3,   16'd2,   16'd272,  16'd2,  16'd10, 16'd10, 16'd0}
    };

    task automatic chk(input string tag, input int act, input int exp_v);
        n_vec++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // one full cycle from a table entry, measured at the ports
    task automatic run_vec(input vec_t v);
        int pre, azc, icsc, connlo, cv, errs, last_addr;
        settle_len_i = v.s; az_len_i = v.z; ics_len_i = v.i; timeout_len_i = v.t;
        corr_mode_i = v.corr; cell_a_i = v.a; cell_b_i = v.b;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        pre = 0; azc = 0; icsc = 0; connlo = 0; last_addr = 0;
        while (!conv_en_o && pre < 5000) begin
            if (pre == 0) begin
                chk("R2 address phase holds amp reset", int'(amp_rst_o), 1);
                chk("R2 first address is cell a", int'(rd_addr_o), int'(v.a));
            end
            if (pre == 1) chk("R2 release without read", int'({amp_rst_o, rd_en_o}), 0);
            if (az_o) azc++;
            if (ics_o) icsc++;
            if (!conn_o) connlo++;
            last_addr = int'(rd_addr_o);
            pre++;
            @(negedge clk);
        end
        chk(v.corr ? "R10 difference setup length" : "R11 single setup length", pre, int'(v.exp_pre));
        chk("R3 auto-zero width", azc, int'(v.exp_az));
        chk("R3 input switch lead", icsc, int'(v.exp_ics));
        chk("R9 connect-low cycles", connlo, int'(v.exp_connlo));
        chk("R9 R11 address before conversion", last_addr, int'(v.corr ? v.b : v.a));
        cv = 0;
        while (conv_en_o && cv < 5000) begin
            cv++;
            if (cv == int'(v.d)) fsc_i = 1'b1;
            @(negedge clk);
        end
        fsc_i = 1'b0;
        chk("R4 conversion width", cv, int'(v.exp_conv));
        chk("R5 load after conversion", int'(load_o), 1);
        @(negedge clk);
        errs = 0;
        for (int k = 0; k < NCH; k++) begin
            if (!(dv_o && int'(chan_o) == k)) errs++;
            @(negedge clk);
        end
        chk("R6 scan order errors", errs, 0);
        chk("R6 valid ends after 32", int'(dv_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int dvc, nload, nconv, ovl, prev_dv, overlap_seen, guard;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 in reset amp_rst", int'(amp_rst_o), 1);
        chk("R1 in reset strobes low", int'({rd_en_o, az_o, ics_o, conv_en_o, load_o, dv_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release idle", int'({amp_rst_o, conn_o, rd_en_o, conv_en_o, dv_o}), 5'b11000);

        foreach (VECS[n]) run_vec(VECS[n]);

        // R7 / R8: overlap of setup with scan, held load, ignored start
        settle_len_i = 16'd1; az_len_i = 16'd1; ics_len_i = 16'd1; timeout_len_i = 16'd9;
        corr_mode_i = 1'b0; cell_a_i = 6'd7;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        guard = 0;
        while (!load_o && guard < 100) begin
            fsc_i = conv_en_o; guard++;
            @(negedge clk);
        end
        fsc_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1; cell_a_i = 6'd12;
        dvc = int'(dv_o); prev_dv = int'(dv_o);
        nload = 0; nconv = 0; ovl = 0; overlap_seen = 0;
        for (int it = 0; it < 120; it++) begin
            @(negedge clk);
            start_i = (it == 2);
            fsc_i = conv_en_o;
            if (load_o) begin
                nload++;
                if (nload == 1) begin
                    chk("R7 load held until scan done", dvc, 32);
                    chk("R7 load right after last valid", prev_dv, 1);
                end
            end
            if (dv_o) dvc++;
            if (load_o && dv_o) ovl++;
            if (conv_en_o) nconv++;
            if (rd_en_o && dv_o) overlap_seen = 1;
            prev_dv = int'(dv_o);
        end
        fsc_i = 1'b0; start_i = 1'b0;
        chk("R7 setup ran during scan", overlap_seen, 1);
        chk("R7 no load with valid", ovl, 0);
        chk("R7 both scans complete", dvc, 64);
        chk("R8 busy start ignored: conversions", nconv, 1);
        chk("R8 busy start ignored: loads", nload, 1);
        chk("R8 idle afterwards", int'({amp_rst_o, conv_en_o}), 2'b10);

        // R1: reset in the middle of a cycle
        settle_len_i = 16'd50;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 mid-cycle read active", int'(rd_en_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-cycle reset idle", int'({amp_rst_o, conn_o, rd_en_o, az_o, ics_o, conv_en_o}), 6'b110000);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        chk("R1 stays idle after reset", int'({amp_rst_o, rd_en_o, conv_en_o, load_o, dv_o}), 5'b10000);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule